// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a set of on-chip peripheral lines and a small group of external pins, keeps one pending flag per source, and tells the processor which source to service next. Each source has its own enable bit, a five-bit priority made of a major level and a sub-level, and a vector offset word that software loads once. Every cycle the controller re-evaluates all pending and enabled sources and presents the winner's number, priority and vector offset on its outputs, together with a single request line.

Each peripheral source is fixed at build time as either a pulse-type source or a held-type source. A pulse-type flag is raised by a low-to-high change of the request line and then remains set until software clears it. A held-type flag is raised again on every cycle the line stays high, so a software clear only takes effect once the peripheral has withdrawn its request. The external pins pass through a synchronizer and raise their flags on one chosen edge. Software reaches all state through a 32-bit register port, and most registers also have clear-bits and set-bits aliases, so a single bit can be changed without a read-modify-write.

Top module: `intc_top`

## Requirements
- R1: After reset, every flag, enable, priority, polarity and vector offset bit reads 0, `irq_req` is 0 and the status register reads 0.
- R2: The control, flag, enable and priority registers each occupy 16 bytes. A write to offset +0x0 replaces the register. A write to +0x4 clears the bits written as 1. A write to +0x8 sets the bits written as 1. Bits written as 0 through the +0x4 and +0x8 aliases keep their value. A read at any of these offsets returns the register.
- R3: Source n has its flag at 0x040 + (n/32)*0x10 and its enable at 0x0C0 + (n/32)*0x10, both at bit n%32. Its priority sits at 0x140 + (n/4)*0x10, in bits (n%4)*8 +: 5. In that field, bits [4:2] are the major level and bits [1:0] are the sub-level. The remaining byte bits, and bits for sources that do not exist, read 0.
- R4: A source is eligible only when its flag is 1, its enable is 1 and its major level is nonzero. `irq_req` is 1 one cycle after any source is eligible, and 0 one cycle after none is.
- R5: Among eligible sources, the highest major level wins. A tie goes to the highest sub-level, and a remaining tie goes to the lowest source number.
- R6: The status register at 0x020 reads as follows: bits [7:0] hold the selected source number, bits [12:8] hold its priority field and bit 16 holds `irq_req`. When nothing is eligible, the whole register reads 0. `irq_src` and `irq_prio` carry the same values.
- R7: A pulse-type peripheral flag is set on the cycle after its line goes from 0 to 1. It then stays set, whatever the line does, until software clears it.
- R8: A held-type peripheral flag is set on every cycle after the line was 1. A software clear while the line is still 1 leaves the flag at 1. The same clear works once the line is 0.
- R9: External pin i maps to source NUM_PERIPH+i. The pin is synchronized through two flops before its edge is detected. Control register bit i selects the edge that sets the flag: 1 means rising, 0 means falling. The other edge has no effect on the flag.
- R10: The vector offset of source n sits at 0x540 + 4*n. Only a plain write reaches it, and bits [VOFF_W-1:0] are stored. `irq_vec` shows the vector offset of the source currently reported on `irq_src`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| periph_req | input | NUM_PERIPH | Peripheral request lines, synchronous to clk |
| ext_pin | input | NUM_EXT | Asynchronous external interrupt pins |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_req | output | 1 | Some source is eligible |
| irq_src | output | 8 | Selected source number |
| irq_prio | output | 5 | Priority field of selected source |
| irq_vec | output | VOFF_W | Vector offset of selected source |

## Verification
A flag register that holds the wrong value shows up at the ports within one cycle. The same cycle's flag-bank read reports it, and the next cycle's status register and `irq_src` report it too, because selection is re-registered every cycle from the current flags. A wrong tie-break or major/sub comparison shows as a different source number one cycle after the priority write that creates the contest. A broken held-type or pulse-type rule shows at the next flag read after a clear write, made while the request line is held or after it has dropped. A synchronizer or polarity fault delays or suppresses an external flag, and the flag read four or more cycles after the pin moves exposes it.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_CLEAR = 2'd1,
        OP_SET   = 2'd2,
        OP_NONE  = 2'd3
    } alias_op_e;

    localparam int CTRL_BASE   = 'h000;
    localparam int STAT_BASE   = 'h020;
    localparam int FLAG_BASE   = 'h040;
    localparam int EN_BASE     = 'h0C0;
    localparam int PRI_BASE    = 'h140;
    localparam int VOFF_BASE   = 'h540;
    localparam int BANK_STRIDE = 'h10;
    localparam int PRI_W       = 5;

    function automatic logic [31:0] apply_op(input logic [31:0] cur,
                                             input logic [31:0] wd,
                                             input alias_op_e op);
        logic [31:0] res;
        case (op)
            OP_WRITE: res = wd;
            OP_CLEAR: res = cur & ~wd;
            OP_SET:   res = cur | wd;
            default:  res = cur;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/intc_ext_edge.sv
module intc_ext_edge #(
    parameter int NUM_EXT = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EXT-1:0] pin_i,
    input  logic [NUM_EXT-1:0] pol_i,
    output logic [NUM_EXT-1:0] event_o
);
    logic [NUM_EXT-1:0] s1_q, s2_q, s3_q;
    logic [1:0]         age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q  <= '0;
            s2_q  <= '0;
            s3_q  <= '0;
            age_q <= '0;
        end else begin
            s1_q <= pin_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
            if (age_q != 2'd3) age_q <= age_q + 2'd1;
        end
    end

    for (genvar i = 0; i < NUM_EXT; i++) begin : g_pin
        assign event_o[i] = pol_i[i] ? (s2_q[i] & ~s3_q[i]) : (~s2_q[i] & s3_q[i]);

        // R9: an event matches the selected edge in the pin's own history
        p_edge_dir_r9: assert property (@(posedge clk) disable iff (rst)
            (age_q == 2'd3) && event_o[i] |->
                (pol_i[i] ? ($past(pin_i[i], 2) && !$past(pin_i[i], 3))
                          : (!$past(pin_i[i], 2) && $past(pin_i[i], 3))));
    end

endmodule

// File: rtl/intc_flags.sv
module intc_flags #(
    parameter int                    NUM_PERIPH = 64,
    parameter int                    NUM_EXT    = 8,
    parameter logic [NUM_PERIPH-1:0] LEVEL_MASK = '0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_PERIPH-1:0]         req_i,
    input  logic [NUM_EXT-1:0]            ext_event_i,
    input  logic [NUM_PERIPH+NUM_EXT-1:0] sw_we_i,
    input  logic [NUM_PERIPH+NUM_EXT-1:0] sw_val_i,
    output logic [NUM_PERIPH+NUM_EXT-1:0] flag_o
);
    localparam int TOTAL = NUM_PERIPH + NUM_EXT;

    logic [NUM_PERIPH-1:0] req_d_q;
    logic [TOTAL-1:0]      hw_set;
    logic [TOTAL-1:0]      flag_q;
    logic                  past_ok_q;

    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_periph
        if (LEVEL_MASK[i]) begin : g_held
            assign hw_set[i] = req_i[i];
            // R8: a held line forces the flag on the next cycle
            p_held_persist_r8: assert property (@(posedge clk) disable iff (rst)
                past_ok_q && $past(req_i[i]) |-> flag_q[i]);
        end else begin : g_pulse
            assign hw_set[i] = req_i[i] & ~req_d_q[i];
            // R7: a pulse flag only falls through a software write
            p_pulse_sticky_r7: assert property (@(posedge clk) disable iff (rst)
                past_ok_q && $past(flag_q[i]) && !$past(sw_we_i[i]) |-> flag_q[i]);
        end
    end

    for (genvar j = 0; j < NUM_EXT; j++) begin : g_ext
        assign hw_set[NUM_PERIPH+j] = ext_event_i[j];
        // R9: external flags are pulse-type
        p_ext_sticky_r9: assert property (@(posedge clk) disable iff (rst)
            past_ok_q && $past(flag_q[NUM_PERIPH+j]) && !$past(sw_we_i[NUM_PERIPH+j])
                |-> flag_q[NUM_PERIPH+j]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q    <= '0;
            req_d_q   <= '0;
            past_ok_q <= 1'b0;
        end else begin
            flag_q    <= ((sw_we_i & sw_val_i) | (~sw_we_i & flag_q)) | hw_set;
            req_d_q   <= req_i;
            past_ok_q <= 1'b1;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
    parameter int TOTAL = 72,
    parameter int SRC_W = 8
) (
    input  logic [TOTAL-1:0]       flag_i,
    input  logic [TOTAL-1:0]       en_i,
    input  logic [TOTAL*5-1:0]     prio_i,
    output logic                   any_o,
    output logic [SRC_W-1:0]       win_o,
    output logic [4:0]             win_prio_o
);
    logic [4:0]       best;
    logic [SRC_W-1:0] idx;
    logic [4:0]       key;

    always_comb begin
        best = '0;
        idx  = '0;
        key  = '0;
        for (int i = 0; i < TOTAL; i++) begin
            key = prio_i[i*5 +: 5];
            // strict compare keeps the lowest number on equal fields
            if (flag_i[i] && en_i[i] && (key[4:2] != 3'd0) && (key > best)) begin
                best = key;
                idx  = SRC_W'(i);
            end
        end
        any_o      = (best != 5'd0);
        win_o      = idx;
        win_prio_o = best;
    end

endmodule

// File: rtl/intc_top.sv
module intc_top #(
    parameter int                    NUM_PERIPH = 64,
    parameter int                    NUM_EXT    = 8,
    parameter int                    VOFF_W     = 16,
    parameter int                    ADDR_W     = 12,
    parameter logic [NUM_PERIPH-1:0] LEVEL_MASK = 64'h0000_0000_FFFF_0000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_PERIPH-1:0] periph_req,
    input  logic [NUM_EXT-1:0]    ext_pin,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  irq_req,
    output logic [7:0]            irq_src,
    output logic [4:0]            irq_prio,
    output logic [VOFF_W-1:0]     irq_vec
);
    import intc_pkg::*;

    localparam int TOTAL  = NUM_PERIPH + NUM_EXT;
    localparam int NBANK  = (TOTAL + 31) / 32;
    localparam int NPRI   = (TOTAL + 3) / 4;
    localparam int SRC_W  = 8;

    logic [NUM_EXT-1:0] ctrl_q;
    logic [TOTAL-1:0]   en_q;
    logic [4:0]         prio_q [TOTAL];
    logic [VOFF_W-1:0]  voff_q [TOTAL];
    logic [TOTAL-1:0]   flag_vec;
    logic [TOTAL*5-1:0] prio_flat;
    logic [NUM_EXT-1:0] ext_event;

    logic               irq_req_q;
    logic [SRC_W-1:0]   irq_src_q;
    logic [4:0]         irq_prio_q;
    logic               arb_any;
    logic [SRC_W-1:0]   arb_win;
    logic [4:0]         arb_prio;

    // ---------------- address decode ----------------
    logic [31:0]  addr32;
    alias_op_e    op;
    logic         hit_ctrl, hit_stat, hit_flag, hit_en, hit_pri, hit_voff;
    int unsigned  flag_bank, en_bank, pri_idx, voff_idx;

    always_comb begin
        addr32    = 32'(bus_addr);
        op        = alias_op_e'(bus_addr[3:2]);
        hit_ctrl  = addr32 < 32'(CTRL_BASE + BANK_STRIDE);
        hit_stat  = (addr32 >= 32'(STAT_BASE)) && (addr32 < 32'(STAT_BASE + BANK_STRIDE));
        hit_flag  = (addr32 >= 32'(FLAG_BASE)) && (addr32 < 32'(FLAG_BASE + NBANK*BANK_STRIDE));
        hit_en    = (addr32 >= 32'(EN_BASE))   && (addr32 < 32'(EN_BASE + NBANK*BANK_STRIDE));
        hit_pri   = (addr32 >= 32'(PRI_BASE))  && (addr32 < 32'(PRI_BASE + NPRI*BANK_STRIDE));
        hit_voff  = (addr32 >= 32'(VOFF_BASE)) && (addr32 < 32'(VOFF_BASE + 4*TOTAL));
        flag_bank = (addr32 - 32'(FLAG_BASE)) >> 4;
        en_bank   = (addr32 - 32'(EN_BASE)) >> 4;
        pri_idx   = (addr32 - 32'(PRI_BASE)) >> 4;
        voff_idx  = (addr32 - 32'(VOFF_BASE)) >> 2;
    end

    // ---------------- register word views ----------------
    function automatic logic [31:0] bank_word(input logic [TOTAL-1:0] v, input int unsigned b);
        logic [31:0] w;
        w = '0;
        for (int k = 0; k < 32; k++) begin
            if (b*32 + k < TOTAL) w[k] = v[b*32 + k];
        end
        return w;
    endfunction

    logic [31:0] ctrl_cur, ctrl_new, flag_cur, flag_new, en_cur, en_new, pri_cur, pri_new;
    logic [31:0] status_word;

    always_comb begin
        ctrl_cur = 32'(ctrl_q);
        flag_cur = bank_word(flag_vec, flag_bank);
        en_cur   = bank_word(en_q, en_bank);
        pri_cur  = '0;
        for (int j = 0; j < 4; j++) begin
            if (pri_idx*4 + j < TOTAL) pri_cur[j*8 +: 5] = prio_q[pri_idx*4 + j];
        end
        ctrl_new = apply_op(ctrl_cur, bus_wdata, op);
        flag_new = apply_op(flag_cur, bus_wdata, op);
        en_new   = apply_op(en_cur, bus_wdata, op);
        pri_new  = apply_op(pri_cur, bus_wdata, op);
        status_word = {15'd0, irq_req_q, 3'd0, irq_prio_q, irq_src_q};
    end

    // ---------------- software flag writes ----------------
    logic [TOTAL-1:0] sw_we, sw_val;

    always_comb begin
        for (int n = 0; n < TOTAL; n++) begin
            sw_we[n]  = bus_we && hit_flag && (n/32 == flag_bank);
            sw_val[n] = flag_new[n%32];
        end
    end

    // ---------------- configuration registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            en_q   <= '0;
            for (int n = 0; n < TOTAL; n++) begin
                prio_q[n] <= '0;
                voff_q[n] <= '0;
            end
        end else if (bus_we) begin
            if (hit_ctrl) ctrl_q <= ctrl_new[NUM_EXT-1:0];
            for (int n = 0; n < TOTAL; n++) begin
                if (hit_en && (n/32 == en_bank))   en_q[n]   <= en_new[n%32];
                if (hit_pri && (n/4 == pri_idx))   prio_q[n] <= pri_new[(n%4)*8 +: 5];
                if (hit_voff && (n == voff_idx))   voff_q[n] <= bus_wdata[VOFF_W-1:0];
            end
        end
    end

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl)      bus_rdata = ctrl_cur;
        else if (hit_stat) bus_rdata = status_word;
        else if (hit_flag) bus_rdata = flag_cur;
        else if (hit_en)   bus_rdata = en_cur;
        else if (hit_pri)  bus_rdata = pri_cur;
        else if (hit_voff) bus_rdata = 32'(voff_q[voff_idx]);
    end

    // ---------------- submodules ----------------
    intc_ext_edge #(.NUM_EXT(NUM_EXT)) u_ext (
        .clk     (clk),
        .rst     (rst),
        .pin_i   (ext_pin),
        .pol_i   (ctrl_q),
        .event_o (ext_event)
    );

    intc_flags #(
        .NUM_PERIPH (NUM_PERIPH),
        .NUM_EXT    (NUM_EXT),
        .LEVEL_MASK (LEVEL_MASK)
    ) u_flags (
        .clk         (clk),
        .rst         (rst),
        .req_i       (periph_req),
        .ext_event_i (ext_event),
        .sw_we_i     (sw_we),
        .sw_val_i    (sw_val),
        .flag_o      (flag_vec)
    );

    for (genvar n = 0; n < TOTAL; n++) begin : g_pflat
        assign prio_flat[n*5 +: 5] = prio_q[n];
    end

    intc_arbiter #(.TOTAL(TOTAL), .SRC_W(SRC_W)) u_arb (
        .flag_i     (flag_vec),
        .en_i       (en_q),
        .prio_i     (prio_flat),
        .any_o      (arb_any),
        .win_o      (arb_win),
        .win_prio_o (arb_prio)
    );

    // ---------------- registered selection ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_req_q  <= 1'b0;
            irq_src_q  <= '0;
            irq_prio_q <= '0;
        end else begin
            irq_req_q  <= arb_any;
            irq_src_q  <= arb_win;
            irq_prio_q <= arb_prio;
        end
    end

    assign irq_req  = irq_req_q;
    assign irq_src  = irq_src_q;
    assign irq_prio = irq_prio_q;
    assign irq_vec  = voff_q[irq_src_q];

    // R6: reported source always exists
    p_src_range_r6: assert property (@(posedge clk) disable iff (rst)
        irq_req_q |-> (32'(irq_src_q) < 32'(TOTAL)));

    // R4: a reported winner never has a zero major level
    p_major_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
        irq_req_q |-> (irq_prio_q[4:2] != 3'd0));

    // R6: idle selection reads as all zero
    p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !irq_req_q |-> (irq_src_q == '0) && (irq_prio_q == '0));

endmodule

// File: tb/tb_intc_top.sv
module tb_intc_top;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_PERIPH = 64;
    localparam int NUM_EXT    = 8;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [NUM_PERIPH-1:0] periph_req = '0;
    logic [NUM_EXT-1:0]    ext_pin = '0;
    logic                  bus_we = 1'b0;
    logic [11:0]           bus_addr = '0;
    logic [31:0]           bus_wdata = '0;
    logic [31:0]           bus_rdata;
    logic                  irq_req;
    logic [7:0]            irq_src;
    logic [4:0]            irq_prio;
    logic [15:0]           irq_vec;

    int checks = 0;
    int errors = 0;

    intc_top dut (
        .clk        (clk),
        .rst        (rst),
        .periph_req (periph_req),
        .ext_pin    (ext_pin),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_req    (irq_req),
        .irq_src    (irq_src),
        .irq_prio   (irq_prio),
        .irq_vec    (irq_vec)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h0C0, 32'h0000_00F0, 32'h0, 4'd2},   // R2 plain write
        '{1'b0, 12'h0C0, 32'h0, 32'h0000_00F0, 4'd2},
        '{1'b1, 12'h0C8, 32'h0000_0003, 32'h0, 4'd2},   // R2 set alias
        '{1'b0, 12'h0C0, 32'h0, 32'h0000_00F3, 4'd2},
        '{1'b1, 12'h0C4, 32'h0000_0030, 32'h0, 4'd2},   // R2 clear alias
        '{1'b0, 12'h0C4, 32'h0, 32'h0000_00C3, 4'd2},
        '{1'b1, 12'h0D0, 32'hFFFF_FFFF, 32'h0, 4'd3},   // R3 second bank
        '{1'b0, 12'h0D0, 32'h0, 32'hFFFF_FFFF, 4'd3},
        '{1'b1, 12'h0E0, 32'hFFFF_FFFF, 32'h0, 4'd3},   // R3 partial bank
        '{1'b0, 12'h0E0, 32'h0, 32'h0000_00FF, 4'd3},
        '{1'b1, 12'h140, 32'hFFFF_FFFF, 32'h0, 4'd3},   // R3 priority lanes
        '{1'b0, 12'h140, 32'h0, 32'h1F1F_1F1F, 4'd3},
        '{1'b1, 12'h144, 32'h0000_1F00, 32'h0, 4'd2},
        '{1'b0, 12'h140, 32'h0, 32'h1F1F_001F, 4'd2},
        '{1'b1, 12'h000, 32'hFFFF_FFFF, 32'h0, 4'd2},   // R2 control
        '{1'b0, 12'h000, 32'h0, 32'h0000_00FF, 4'd2},
        '{1'b1, 12'h004, 32'h0000_00FF, 32'h0, 4'd2},
        '{1'b0, 12'h008, 32'h0, 32'h0000_0000, 4'd2},
        '{1'b1, 12'h554, 32'h1234_ABCD, 32'h0, 4'd10},  // R10 source 5
        '{1'b0, 12'h554, 32'h0, 32'h0000_ABCD, 4'd10},
        '{1'b0, 12'h020, 32'h0, 32'h0000_0000, 4'd6},   // R6 no flags
        '{1'b1, 12'h0C0, 32'h0, 32'h0, 4'd2},
        '{1'b1, 12'h0D0, 32'h0, 32'h0, 4'd2},
        '{1'b1, 12'h0E0, 32'h0, 32'h0, 4'd2},
        '{1'b1, 12'h140, 32'h0, 32'h0, 4'd2},
        '{1'b0, 12'h0C0, 32'h0, 32'h0, 4'd2}
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata, exp, tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual run still active expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(5);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        check({31'd0, irq_req}, 32'd0, "R1 irq_req");
        rd(12'h020, 32'h0, "R1 status");
        rd(12'h040, 32'h0, "R1 flags");
        rd(12'h0C0, 32'h0, "R1 enables");
        rd(12'h000, 32'h0, "R1 polarity");

        // table walk: alias and layout behaviour
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
            else rd(VECS[i].addr, VECS[i].exp, $sformatf("R%0d vec%0d", VECS[i].req, i));
        end

        // R4 / R5 / R6 arbitration
        wr(12'h140, 32'h0900_0000);          // source 3: major 2 sub 1
        wr(12'h150, 32'h0000_0900);          // source 5: major 2 sub 1
        wr(12'h048, 32'h0000_0028);          // flags 3 and 5
        rd(12'h020, 32'h0, "R4 flags without enable");
        wr(12'h0C8, 32'h0000_0028);
        rd(12'h020, 32'h0001_0903, "R5 tie lowest number, R6 status");
        check({24'd0, irq_src}, 32'd3, "R6 irq_src");
        wr(12'h150, 32'h0000_0A00);          // source 5 sub 2
        rd(12'h020, 32'h0001_0A05, "R5 sub-level wins");
        check({16'd0, irq_vec}, 32'h0000_ABCD, "R10 irq_vec");
        wr(12'h1E0, 32'h0000_000C);          // source 40: major 3
        wr(12'h058, 32'h0000_0100);
        wr(12'h0D8, 32'h0000_0100);
        rd(12'h020, 32'h0001_0C28, "R5 major wins");
        wr(12'h1E0, 32'h0000_0003);          // major 0, sub 3
        rd(12'h020, 32'h0001_0A05, "R4 zero major ineligible");
        wr(12'h044, 32'h0000_0028);
        wr(12'h054, 32'h0000_0100);
        idle(1);
        check({31'd0, irq_req}, 32'd0, "R4 irq_req drops");

        // R7 pulse-type source 3
        @(negedge clk); periph_req[3] = 1'b1;
        @(negedge clk); periph_req[3] = 1'b0;
        idle(3);
        rd(12'h040, 32'h0000_0008, "R7 pulse flag stays");
        wr(12'h044, 32'h0000_0008);
        rd(12'h040, 32'h0, "R7 software clear");

        // R8 held-type source 20
        @(negedge clk); periph_req[20] = 1'b1;
        idle(2);
        rd(12'h040, 32'h0010_0000, "R8 held flag set");
        wr(12'h044, 32'h0010_0000);
        rd(12'h040, 32'h0010_0000, "R8 clear ignored while held");
        @(negedge clk); periph_req[20] = 1'b0;
        idle(1);
        wr(12'h044, 32'h0010_0000);
        rd(12'h040, 32'h0, "R8 clear after release");

        // R9 external pins: source 66 rising, source 69 falling
        wr(12'h008, 32'h0000_0004);
        @(negedge clk); ext_pin[2] = 1'b1;
        idle(5);
        rd(12'h060, 32'h0000_0004, "R9 rising edge pin 2");
        @(negedge clk); ext_pin[5] = 1'b1;
        idle(5);
        rd(12'h060, 32'h0000_0004, "R9 rising ignored pin 5");
        @(negedge clk); ext_pin[5] = 1'b0;
        idle(5);
        rd(12'h060, 32'h0000_0024, "R9 falling edge pin 5");
        wr(12'h064, 32'h0000_0024);
        @(negedge clk); ext_pin[2] = 1'b0;
        idle(5);
        rd(12'h060, 32'h0, "R9 falling ignored pin 2");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule